// File: doc/BRIEF.md
# Time-Shared Complex FIR Section

This block is a 32-tap complex FIR filter section built around a small bank of shared complex multipliers. Samples arrive at a quarter of the processing clock rate. A four-cycle sample slot is enough for eight physical multipliers to work through all 32 taps, with each multiplier taking four taps in turn. The slow sample clock is modelled as a qualifier on the fast clock. A sample is taken when `inValid` is high and the previous sample's multiply run has reached its final phase. After that, a new sample may be presented every fourth cycle.

Each multiplier registers its complex product. A per-multiplier accumulator then folds that product into a partial sum on the next cycle, while the multiplier is already working on the following tap. The eight partial sums pass through a registered three-level adder tree. The result is the full-precision complex sum, produced once for each accepted sample after a fixed number of cycles. Coefficients are written one tap at a time through an address, data and write-enable port while no multiply run is in progress.

Top module: `cfirSection`

## Requirements
- R1: After reset, `outValid` is low, `outI` and `outQ` are zero, every delay-line entry holds zero and every coefficient is zero. A sample accepted before any coefficient write therefore produces a zero result.
- R2: Each accepted sample gives exactly one `outValid` pulse, one cycle wide. The pulse is high in the cycle that begins 9 rising edges after the edge that captured the sample. Rejected samples give no pulse.
- R3: The result for sample n is the sum over k = 0..31 of c[k]·x[n−k]. Here x[n−k] is the k-th most recently accepted sample, with k = 0 being the sample just accepted, and c[k] is the coefficient written at `coefAddr` = k. Delay-line entries not yet filled count as zero.
- R4: Each tap's product is the complex product (a+jb)(c+jd) = (ac−bd) + j(ad+bc). Here a and b are the sample's I and Q parts, c and d are the coefficient's I and Q parts, and all operands are 16-bit two's complement.
- R5: `outI` and `outQ` are 38-bit two's complement and carry the exact sum with no wrap. This includes the case where every tap holds the largest-magnitude operands.
- R6: `inValid` is accepted on an edge only if at least 4 edges have passed since the previous accepted edge. If it arrives sooner, it does not shift the delay line and does not produce an output.
- R7: A coefficient write (`coefWe` high) takes effect on its edge, except on the 4 edges that follow an accepting edge, where it is ignored. Those 4 edges form the multiply run.
- R8: `outI` and `outQ` keep their value in every cycle in which `outValid` is low.
- R9: Samples presented exactly every 4 cycles are all accepted. Each one yields its own correct result, so the section sustains one complex output per sample slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample present on inI/inQ |
| inI | input | 16 | Sample real part, signed |
| inQ | input | 16 | Sample imaginary part, signed |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 5 | Tap index to write (0 = newest sample) |
| coefI | input | 16 | Coefficient real part, signed |
| coefQ | input | 16 | Coefficient imaginary part, signed |
| outValid | output | 1 | One-cycle result strobe |
| outI | output | 38 | Result real part, signed |
| outQ | output | 38 | Result imaginary part, signed |

## Verification
The hardest case to reach from the ports is one where a multiply run overlaps other activity. This covers a new sample accepted in the run's last phase, a coefficient write landing inside a run, and a second `inValid` arriving one to three cycles after the first. The stimulus produces each of these on purpose. Back-to-back samples are issued at exactly four-cycle spacing. Extra `inValid` pulses and coefficient writes are placed at every offset inside a run. The scoreboard's model applies the same acceptance and write-blocking rules, so any drift in phase alignment shows up as a wrong value or a wrong cycle. A separate run fills every tap with the largest-magnitude operands to exercise the output width.

// File: rtl/cfirPkg.sv
package cfirPkg;

  // Taps per shared multiplier is 1 << PHASE_W; fixed by the architecture.
  localparam int PHASE_W = 2;
  localparam int SHARE   = 1 << PHASE_W;

  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic               shiftEn;    // capture a new sample into the delay line
    logic               mulActive;  // multipliers working this cycle
    logic [PHASE_W-1:0] mulPhase;   // tap within each group of SHARE
    logic               prodValid;  // product registers hold a fresh product
    logic               prodFirst;  // that product is phase 0: restart accumulators
    logic               rootValid;  // adder tree root holds a finished sum
  } cfirStrobes_t;

endpackage

// File: rtl/cfirCtrl.sv
module cfirCtrl
  import cfirPkg::*;
#(
  parameter int TREE_LVLS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output cfirStrobes_t strobes,
  output logic         outValid
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(SHARE - 1);

  logic               runActive;
  logic [PHASE_W-1:0] runPhase;
  logic               accept;
  logic               prodValid;
  logic [PHASE_W-1:0] prodPhase;
  logic               accDone;
  logic [TREE_LVLS-1:0] treePipe;

  // A sample may start a run when idle or when the current run is in its last phase.
  assign accept = inValid && (!runActive || runPhase == LAST_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runActive <= 1'b0;
      runPhase  <= '0;
      prodValid <= 1'b0;
      prodPhase <= '0;
      accDone   <= 1'b0;
      treePipe  <= '0;
      outValid  <= 1'b0;
    end else begin
      if (accept) begin
        runActive <= 1'b1;
        runPhase  <= '0;
      end else if (runActive) begin
        runPhase <= runPhase + 1'b1;
        if (runPhase == LAST_PHASE) runActive <= 1'b0;
      end
      prodValid   <= runActive;
      prodPhase   <= runPhase;
      accDone     <= prodValid && (prodPhase == LAST_PHASE);
      treePipe[0] <= accDone;
      for (int i = 1; i < TREE_LVLS; i++) treePipe[i] <= treePipe[i-1];
      outValid    <= treePipe[TREE_LVLS-1];
    end
  end

  assign strobes.shiftEn   = accept;
  assign strobes.mulActive = runActive;
  assign strobes.mulPhase  = runPhase;
  assign strobes.prodValid = prodValid;
  assign strobes.prodFirst = prodValid && (prodPhase == '0);
  assign strobes.rootValid = treePipe[TREE_LVLS-1];

  // R2: one result strobe per sample, never two in a row
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !outValid);

  // R6: an accepted sample always opens a run at phase 0
  assert_run_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (runActive && runPhase == '0));

  // R9: a run steps through every phase without gaps
  assert_phase_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (runActive && runPhase != LAST_PHASE) |=>
      (runActive && runPhase == $past(runPhase) + PHASE_W'(1)));

endmodule

// File: rtl/cfirLane.sv
module cfirLane
  import cfirPkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int COEF_W = 16,
  localparam int PROD_W = DATA_W + COEF_W + 1,
  localparam int ACC_W  = PROD_W + PHASE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prodEn,
  input  logic                     accEn,
  input  logic                     accLoad,
  input  logic signed [DATA_W-1:0] xI,
  input  logic signed [DATA_W-1:0] xQ,
  input  logic signed [COEF_W-1:0] cI,
  input  logic signed [COEF_W-1:0] cQ,
  output logic signed [ACC_W-1:0]  accI,
  output logic signed [ACC_W-1:0]  accQ
);

  localparam int MUL_W = DATA_W + COEF_W;

  logic signed [MUL_W-1:0]  mII, mQQ, mIQ, mQI;
  logic signed [PROD_W-1:0] prodI, prodQ;
  logic signed [ACC_W-1:0]  extI, extQ;

  // Four full-precision partial products of the complex multiply.
  assign mII = xI * cI;
  assign mQQ = xQ * cQ;
  assign mIQ = xI * cQ;
  assign mQI = xQ * cI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prodI <= '0;
      prodQ <= '0;
    end else if (prodEn) begin
      prodI <= {mII[MUL_W-1], mII} - {mQQ[MUL_W-1], mQQ};
      prodQ <= {mIQ[MUL_W-1], mIQ} + {mQI[MUL_W-1], mQI};
    end
  end

  assign extI = {{PHASE_W{prodI[PROD_W-1]}}, prodI};
  assign extQ = {{PHASE_W{prodQ[PROD_W-1]}}, prodQ};

  // Accumulation runs one cycle behind the multiply, never chained with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accI <= '0;
      accQ <= '0;
    end else if (accEn) begin
      accI <= accLoad ? extI : accI + extI;
      accQ <= accLoad ? extQ : accQ + extQ;
    end
  end

endmodule

// File: rtl/cfirDatapath.sv
module cfirDatapath
  import cfirPkg::*;
#(
  parameter  int NUM_TAPS  = 32,
  parameter  int DATA_W    = 16,
  parameter  int COEF_W    = 16,
  localparam int NUM_MULT  = NUM_TAPS / SHARE,
  localparam int TREE_LVLS = $clog2(NUM_MULT),
  localparam int TAP_AW    = $clog2(NUM_TAPS),
  localparam int ACC_W     = DATA_W + COEF_W + 1 + PHASE_W,
  localparam int OUT_W     = ACC_W + TREE_LVLS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cfirStrobes_t             strobes,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     coefWe,
  input  logic [TAP_AW-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefI,
  input  logic signed [COEF_W-1:0] coefQ,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);

  localparam int LANE_AW = TAP_AW - PHASE_W;

  logic [NUM_TAPS-1:0][DATA_W-1:0] dlyI, dlyQ;
  logic [NUM_TAPS-1:0][COEF_W-1:0] coefIBank, coefQBank;

  // Delay line: entry 0 holds the newest sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlyI <= '0;
      dlyQ <= '0;
    end else if (strobes.shiftEn) begin
      dlyI[0] <= inI;
      dlyQ[0] <= inQ;
      for (int k = 1; k < NUM_TAPS; k++) begin
        dlyI[k] <= dlyI[k-1];
        dlyQ[k] <= dlyQ[k-1];
      end
    end
  end

  // Coefficient bank: writes are held off while a run reads it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coefIBank <= '0;
      coefQBank <= '0;
    end else if (coefWe && !strobes.mulActive) begin
      coefIBank[coefAddr] <= coefI;
      coefQBank[coefAddr] <= coefQ;
    end
  end

  logic signed [ACC_W-1:0] laneAccI [NUM_MULT];
  logic signed [ACC_W-1:0] laneAccQ [NUM_MULT];
  logic signed [OUT_W-1:0] leafI    [NUM_MULT];
  logic signed [OUT_W-1:0] leafQ    [NUM_MULT];

  // Lane m handles taps m*SHARE .. m*SHARE+SHARE-1, one per phase.
  for (genvar m = 0; m < NUM_MULT; m++) begin : gLane
    logic [TAP_AW-1:0] tapSel;
    assign tapSel = {LANE_AW'(m), strobes.mulPhase};

    cfirLane #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W)
    ) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .prodEn  (strobes.mulActive),
      .accEn   (strobes.prodValid),
      .accLoad (strobes.prodFirst),
      .xI      (dlyI[tapSel]),
      .xQ      (dlyQ[tapSel]),
      .cI      (coefIBank[tapSel]),
      .cQ      (coefQBank[tapSel]),
      .accI    (laneAccI[m]),
      .accQ    (laneAccQ[m])
    );

    assign leafI[m] = {{TREE_LVLS{laneAccI[m][ACC_W-1]}}, laneAccI[m]};
    assign leafQ[m] = {{TREE_LVLS{laneAccQ[m][ACC_W-1]}}, laneAccQ[m]};
  end

  // Registered adder tree in heap order: node 1 is the root, node i feeds from 2i and 2i+1.
  logic signed [OUT_W-1:0] nodeI [1:NUM_MULT-1];
  logic signed [OUT_W-1:0] nodeQ [1:NUM_MULT-1];

  for (genvar n = 1; n < NUM_MULT; n++) begin : gNode
    logic signed [OUT_W-1:0] aI, bI, aQ, bQ;
    if (2 * n >= NUM_MULT) begin : gFromLeaf
      assign aI = leafI[2*n - NUM_MULT];
      assign bI = leafI[2*n + 1 - NUM_MULT];
      assign aQ = leafQ[2*n - NUM_MULT];
      assign bQ = leafQ[2*n + 1 - NUM_MULT];
    end else begin : gFromNode
      assign aI = nodeI[2*n];
      assign bI = nodeI[2*n + 1];
      assign aQ = nodeQ[2*n];
      assign bQ = nodeQ[2*n + 1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        nodeI[n] <= '0;
        nodeQ[n] <= '0;
      end else begin
        nodeI[n] <= aI + bI;
        nodeQ[n] <= aQ + bQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outI <= '0;
      outQ <= '0;
    end else if (strobes.rootValid) begin
      outI <= nodeI[1];
      outQ <= nodeQ[1];
    end
  end

  // R7: coefficients cannot move under a running multiply
  assert_coef_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.mulActive |=> ($stable(coefIBank) && $stable(coefQBank)));

  // R8: result registers only change when a finished sum is presented
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rootValid |=> ($stable(outI) && $stable(outQ)));

  // R6: delay line moves only when a sample is accepted
  assert_dly_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.shiftEn |=> ($stable(dlyI) && $stable(dlyQ)));

endmodule

// File: rtl/cfirSection.sv
module cfirSection
  import cfirPkg::*;
#(
  parameter  int NUM_TAPS  = 32,
  parameter  int DATA_W    = 16,
  parameter  int COEF_W    = 16,
  localparam int NUM_MULT  = NUM_TAPS / SHARE,
  localparam int TREE_LVLS = $clog2(NUM_MULT),
  localparam int TAP_AW    = $clog2(NUM_TAPS),
  localparam int OUT_W     = DATA_W + COEF_W + 1 + PHASE_W + TREE_LVLS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     coefWe,
  input  logic [TAP_AW-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefI,
  input  logic signed [COEF_W-1:0] coefQ,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);

  cfirStrobes_t strobes;

  cfirCtrl #(
    .TREE_LVLS (TREE_LVLS)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  cfirDatapath #(
    .NUM_TAPS (NUM_TAPS),
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .inI      (inI),
    .inQ      (inQ),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefI    (coefI),
    .coefQ    (coefQ),
    .outI     (outI),
    .outQ     (outQ)
  );

endmodule

// File: tb/test_cfirSection.sv
module test_cfirSection;

  localparam int TAPS  = 32;
  localparam int OUT_W = 38;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    inValid = 1'b0;
  logic signed [15:0]      inI = '0, inQ = '0;
  logic                    coefWe = 1'b0;
  logic [4:0]              coefAddr = '0;
  logic signed [15:0]      coefI = '0, coefQ = '0;
  logic                    outValid;
  logic signed [OUT_W-1:0] outI, outQ;

  cfirSection i_cfirSection (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inI(inI), .inQ(inQ),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefI(coefI), .coefQ(coefQ),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    longint eI;
    longint eQ;
    int     due;
    string  tag;
  } expItem_t;

  expItem_t sb[$];

  // Reference model state
  longint mCI [TAPS];
  longint mCQ [TAPS];
  longint hI  [TAPS];
  longint hQ  [TAPS];
  int     lastAcc = -100;

  task automatic report(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // One driven cycle; the model applies the same acceptance and write rules.
  task automatic tick(input bit vld, input int di, input int dq,
                      input bit we, input int wa, input int wi, input int wq,
                      input string tag);
    int e;
    @(negedge clk);
    e = cyc + 1;
    if (we && !((e - lastAcc) >= 1 && (e - lastAcc) <= 4)) begin
      mCI[wa] = longint'(wi);
      mCQ[wa] = longint'(wq);
    end
    if (vld && (e - lastAcc) >= 4) begin
      expItem_t it;
      for (int k = TAPS - 1; k > 0; k--) begin
        hI[k] = hI[k-1];
        hQ[k] = hQ[k-1];
      end
      hI[0] = longint'(di);
      hQ[0] = longint'(dq);
      it.eI = 0;
      it.eQ = 0;
      for (int k = 0; k < TAPS; k++) begin
        it.eI += hI[k] * mCI[k] - hQ[k] * mCQ[k];
        it.eQ += hI[k] * mCQ[k] + hQ[k] * mCI[k];
      end
      it.due = e + 9;
      it.tag = tag;
      sb.push_back(it);
      lastAcc = e;
    end
    inValid  = vld;
    inI      = 16'(di);
    inQ      = 16'(dq);
    coefWe   = we;
    coefAddr = 5'(wa);
    coefI    = 16'(wi);
    coefQ    = 16'(wq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic sample(input int di, input int dq, input string tag);
    tick(1, di, dq, 0, 0, 0, 0, tag);
    idle(3);
  endtask

  task automatic loadCoef(input int a, input int ci, input int cq);
    tick(0, 0, 0, 1, a, ci, cq, "R7");
  endtask

  // Monitor: compare results in order, and check timing and hold behaviour.
  logic signed [OUT_W-1:0] prevI = '0, prevQ = '0;
  bit monOn = 1'b0;

  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          report(1'b0, "R2", "unexpected outValid", 1, 0);
        end else begin
          expItem_t it;
          it = sb.pop_front();
          report(cyc == it.due, "R2", "output cycle", cyc, it.due);
          report(longint'(outI) == it.eI, it.tag, "outI", longint'(outI), it.eI);
          report(longint'(outQ) == it.eQ, it.tag, "outQ", longint'(outQ), it.eQ);
        end
      end else begin
        report(outI == prevI && outQ == prevQ, "R8", "hold outI", longint'(outI), longint'(prevI));
        if (sb.size() != 0 && sb[0].due < cyc) begin
          report(1'b0, "R2", "missing outValid due", cyc, sb[0].due);
          void'(sb.pop_front());
        end
      end
      prevI = outI;
      prevQ = outQ;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      mCI[k] = 0; mCQ[k] = 0; hI[k] = 0; hQ[k] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    report(outValid == 1'b0, "R1", "outValid after reset", longint'(outValid), 0);
    report(outI == '0, "R1", "outI after reset", longint'(outI), 0);
    report(outQ == '0, "R1", "outQ after reset", longint'(outQ), 0);
    rst_n = 1'b1;
    monOn = 1'b1;
    idle(2);

    // R1: coefficients are zero before any write
    sample(1000, -500, "R1");
    sample(-32768, 32767, "R1");
    idle(12);

    // R3: impulse reads the taps back in address order
    for (int k = 0; k < TAPS; k++) loadCoef(k, k + 1, -3 * k);
    idle(2);
    sample(1, 0, "R3");
    for (int k = 0; k < TAPS + 2; k++) sample(0, 0, "R3");
    sample(0, 1, "R3");
    idle(12);

    // R4, R9: random coefficients and random samples at full rate
    for (int k = 0; k < TAPS; k++) loadCoef(k, int'(shortint'($urandom)), int'(shortint'($urandom)));
    for (int n = 0; n < 48; n++) sample(int'(shortint'($urandom)), int'(shortint'($urandom)), "R9");
    sample(3, 4, "R4");
    idle(12);

    // R5: largest-magnitude operands on every tap
    for (int k = 0; k < TAPS; k++) loadCoef(k, -32768, 32767);
    for (int n = 0; n < TAPS + 2; n++) sample(-32768, -32768, "R5");
    for (int k = 0; k < TAPS; k++) loadCoef(k, -32768, -32768);
    for (int n = 0; n < TAPS + 2; n++) sample(-32768, 32767, "R5");
    idle(12);

    // R6: extra valids 1, 2 and 3 cycles into a run are ignored
    for (int k = 0; k < TAPS; k++) loadCoef(k, 7 * k - 50, 100 - k);
    for (int r = 0; r < 4; r++) begin
      tick(1, 100 + r, -200, 0, 0, 0, 0, "R6");
      tick(1, 9999, 9999, 0, 0, 0, 0, "R6");
      tick(1, 8888, -8888, 0, 0, 0, 0, "R6");
      tick(1, -7777, 7777, 0, 0, 0, 0, "R6");
    end
    idle(12);

    // R7: coefficient writes inside a run are ignored, outside it they land
    for (int off = 1; off <= 4; off++) begin
      tick(1, 321, -123, 0, 0, 0, 0, "R7");
      for (int j = 1; j < off; j++) tick(0, 0, 0, 0, 0, 0, 0, "");
      tick(0, 0, 0, 1, 0, 30000, -30000, "");
      idle(6);
      sample(50, 60, "R7");
      idle(6);
    end
    loadCoef(0, 1234, -4321);
    sample(77, -88, "R7");
    idle(12);

    // R2: irregular gaps between samples
    for (int g = 0; g < 6; g++) begin
      tick(1, 1000 * g - 2500, 300 - 50 * g, 0, 0, 0, 0, "R2");
      idle(3 + 2 * g);
    end
    idle(16);

    report(sb.size() == 0, "R2", "results outstanding at end", sb.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule